// File: doc/BRIEF.md
# Receive Fill-Level Flow Control for the RTS Line

This block decides when a serial receiver asks its link partner to pause. It takes the current fill level of the receive FIFO and a programmable 6-bit threshold. From these it raises a status-only trigger flag and, when hardware flow control is selected, drives the RTS output. The FIFO itself lives elsewhere. Only its occupancy count comes into this block.

The trigger deasserts RTS as soon as the FIFO fills up to the threshold. RTS comes back only after the FIFO has drained four entries below the threshold, so the line does not chatter while the level hovers near the limit. A threshold below 4 turns the function off. When hardware flow control is not selected, the RTS pin simply follows a software request bit. Both outputs are registered and change one clock after the inputs that cause them.

The trigger flag is meant to be read as a status bit. The block produces no interrupt from it.

Top module: `rxfc_rts_ctrl`

## Requirements
- R1: `flow_trig` is 1 in the cycle after `fill_level >= flow_thr` with `flow_thr >= 4`, and is 0 in the cycle after any other input combination; a level of exactly `flow_thr` counts as reached, and `flow_thr - 1` does not.
- R2: `flow_trig` does not depend on `hw_flow_en` or `sw_rts_req`; it reports the level comparison in both flow modes.
- R3: With `hw_flow_en = 1` and a valid threshold, `rts_n` is 1 (RTS inactive) in the cycle after the level reaches the threshold.
- R4: With `hw_flow_en = 1` and a valid threshold, `rts_n` is 0 (RTS active) in the cycle after `fill_level + 4 <= flow_thr`.
- R5: With `hw_flow_en = 1`, a valid threshold and a level strictly between `flow_thr - 4` and `flow_thr`, `rts_n` keeps its previous value (hysteresis).
- R6: A `flow_thr` value of 0 to 3 disables the function: `flow_trig` stays 0 and, with `hw_flow_en = 1`, `rts_n` is 0 in the following cycle, whatever the fill level.
- R7: With `hw_flow_en = 0`, `rts_n` equals the inverse of `sw_rts_req` one cycle later.
- R8: With `hw_flow_en = 1`, `sw_rts_req` has no effect on `rts_n`.
- R9: A synchronous reset (`rst_n = 0` at a clock edge) leaves `rts_n = 0` (RTS active, ready to receive) and `flow_trig = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fill_level | input | LEVEL_W (7) | Current receive FIFO occupancy, 0 to 64 |
| flow_thr | input | THR_W (6) | Flow threshold; values below 4 disable the function |
| hw_flow_en | input | 1 | 1 selects hardware flow control, 0 selects software RTS |
| sw_rts_req | input | 1 | Software RTS request, 1 = RTS active; used only when `hw_flow_en = 0` |
| rts_n | output | 1 | RTS pin, active low, registered |
| flow_trig | output | 1 | Trigger status flag, registered, never an interrupt |

## Verification
The only internal state is the RTS decision flop and the registered trigger. A wrong state therefore shows up on `rts_n` or `flow_trig` exactly one clock after the inputs that should have set it. The hysteresis band is the case that exposes a wrong RTS state. There a design that lost or inverted its memory shows the wrong `rts_n` for as long as the level stays inside the band, instead of the value carried over from the last crossing. The bench walks the level up and down through both edges of the band and across mode switches, so a flop that misses an update is seen on the next sampled cycle.

// File: rtl/rxfc_pkg.sv
// Shared types for the receive flow-control block.
package rxfc_pkg;

    // Decision applied to the RTS state register in a given cycle.
    typedef enum logic [1:0] {
        RTS_KEEP      = 2'd0,  // hold the current state (hysteresis band)
        RTS_SET_ON    = 2'd1,  // request data from the partner
        RTS_SET_OFF   = 2'd2,  // ask the partner to pause
        RTS_FOLLOW_SW = 2'd3   // copy the software request
    } rts_action_e;

endpackage

// File: rtl/rxfc_level_cmp.sv
// Level comparator: compares the FIFO fill level with the flow threshold.
// Produces three flags:
//   - threshold validity;
//   - whether the trigger level has been reached;
//   - whether the level has drained far enough to release RTS.
// Assumes both inputs are unsigned.
// Both operands are widened to a common width so that either may be the wider one.
module rxfc_level_cmp #(
    parameter int LEVEL_W = 7,
    parameter int THR_W   = 6,
    parameter int HYST    = 4,
    parameter int MIN_THR = 4
) (
    input  logic [LEVEL_W-1:0] fill_level,
    input  logic [THR_W-1:0]   flow_thr,
    output logic               thr_valid,
    output logic               level_hit,
    output logic               release_ok
);
    localparam int CMP_W = ((LEVEL_W > THR_W) ? LEVEL_W : THR_W) + 1;

    logic [CMP_W-1:0] level_x;
    logic [CMP_W-1:0] thr_x;

    // Zero-extend whichever operand is narrower.
    generate
        if (LEVEL_W >= THR_W) begin : g_level_wide
            assign level_x = {{(CMP_W-LEVEL_W){1'b0}}, fill_level};
            assign thr_x   = {{(CMP_W-THR_W){1'b0}}, flow_thr};
        end else begin : g_thr_wide
            assign thr_x   = {{(CMP_W-THR_W){1'b0}}, flow_thr};
            assign level_x = {{(CMP_W-LEVEL_W){1'b0}}, fill_level};
        end
    endgenerate

    // Purpose: derive the three comparison flags from the widened operands.
    always_comb begin
        thr_valid  = (thr_x >= CMP_W'(MIN_THR));
        level_hit  = thr_valid && (level_x >= thr_x);
        release_ok = thr_valid && ((level_x + CMP_W'(HYST)) <= thr_x);
    end

endmodule

// File: rtl/rxfc_rts_policy.sv
// RTS policy: selects the action for the RTS state register.
// Inputs are the flow mode and the comparator flags; the logic is purely
// combinational.
// Assumes level_hit and release_ok are never both 1.
module rxfc_rts_policy
    import rxfc_pkg::*;
(
    input  logic        hw_flow_en,
    input  logic        thr_valid,
    input  logic        level_hit,
    input  logic        release_ok,
    output rts_action_e action
);
    // Purpose: priority decode; in hardware mode the software bit is ignored.
    always_comb begin
        if (!hw_flow_en) begin
            action = RTS_FOLLOW_SW;
        end else if (!thr_valid) begin
            action = RTS_SET_ON;
        end else if (level_hit) begin
            action = RTS_SET_OFF;
        end else if (release_ok) begin
            action = RTS_SET_ON;
        end else begin
            action = RTS_KEEP;
        end
    end

endmodule

// File: rtl/rxfc_state_regs.sv
// State registers: the RTS state flop and the registered trigger flag.
// The reset is synchronous and active low.
// After reset, RTS is active and the trigger is clear.
module rxfc_state_regs
    import rxfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  rts_action_e action,
    input  logic        sw_rts_req,
    input  logic        trig_next,
    output logic        rts_on,
    output logic        trig_q
);
    // Purpose: apply the selected action to the RTS state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rts_on <= 1'b1;
        end else begin
            unique case (action)
                RTS_SET_ON:    rts_on <= 1'b1;
                RTS_SET_OFF:   rts_on <= 1'b0;
                RTS_FOLLOW_SW: rts_on <= sw_rts_req;
                default:       rts_on <= rts_on;
            endcase
        end
    end

    // Purpose: register the status-only trigger flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
        end else begin
            trig_q <= trig_next;
        end
    end

endmodule

// File: rtl/rxfc_rts_ctrl.sv
// Top level: receive FIFO flow control for the RTS line.
// The block compares the FIFO fill level with a programmable threshold.
// It drives the active-low RTS pin with four entries of hysteresis and
// reports a status-only trigger flag.
// Both outputs come straight from flops.
// Assumes fill_level is already synchronous to clk.
module rxfc_rts_ctrl
    import rxfc_pkg::*;
#(
    parameter int LEVEL_W = 7,
    parameter int THR_W   = 6,
    parameter int HYST    = 4,
    parameter int MIN_THR = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEVEL_W-1:0] fill_level,
    input  logic [THR_W-1:0]   flow_thr,
    input  logic               hw_flow_en,
    input  logic               sw_rts_req,
    output logic               rts_n,
    output logic               flow_trig
);
    logic        thr_valid;
    logic        level_hit;
    logic        release_ok;
    logic        rts_on;
    rts_action_e action;

    rxfc_level_cmp #(
        .LEVEL_W (LEVEL_W),
        .THR_W   (THR_W),
        .HYST    (HYST),
        .MIN_THR (MIN_THR)
    ) i_cmp (
        .fill_level (fill_level),
        .flow_thr   (flow_thr),
        .thr_valid  (thr_valid),
        .level_hit  (level_hit),
        .release_ok (release_ok)
    );

    rxfc_rts_policy i_policy (
        .hw_flow_en (hw_flow_en),
        .thr_valid  (thr_valid),
        .level_hit  (level_hit),
        .release_ok (release_ok),
        .action     (action)
    );

    rxfc_state_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .action     (action),
        .sw_rts_req (sw_rts_req),
        .trig_next  (level_hit),
        .rts_on     (rts_on),
        .trig_q     (flow_trig)
    );

    // Purpose: the pin is active low.
    assign rts_n = ~rts_on;

endmodule

// File: rtl/rxfc_rts_ctrl_chk.sv
// Checker for rxfc_rts_ctrl.
// It relates the port inputs of one cycle to the registered outputs of the
// next cycle.
// It is attached to every instance of the top module through bind.
module rxfc_rts_ctrl_chk #(
    parameter int LEVEL_W = 7,
    parameter int THR_W   = 6,
    parameter int HYST    = 4,
    parameter int MIN_THR = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LEVEL_W-1:0] fill_level,
    input logic [THR_W-1:0]   flow_thr,
    input logic               hw_flow_en,
    input logic               sw_rts_req,
    input logic               rts_n,
    input logic               flow_trig
);
    int lvl_i;
    int thr_i;
    logic thr_ok;

    assign lvl_i  = int'(fill_level);
    assign thr_i  = int'(flow_thr);
    assign thr_ok = (thr_i >= MIN_THR);

    // R1: reaching the threshold sets the status flag next cycle
    p_trig_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_ok && lvl_i >= thr_i) |=> flow_trig);

    // R1: below the threshold the flag is clear next cycle
    p_trig_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_i < thr_i) |=> !flow_trig);

    // R3: trigger deasserts RTS in hardware mode
    p_rts_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_flow_en && thr_ok && lvl_i >= thr_i) |=> rts_n);

    // R4: draining four below the threshold reasserts RTS
    p_rts_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_flow_en && thr_ok && lvl_i + HYST <= thr_i) |=> !rts_n);

    // R5: inside the band RTS holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_flow_en && thr_ok && lvl_i < thr_i && lvl_i + HYST > thr_i) |=> $stable(rts_n));

    // R6: small thresholds disable the function
    p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!thr_ok) |=> (!flow_trig && (!$past(hw_flow_en) || !rts_n)));

    // R7: software mode copies the request bit
    p_sw_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_flow_en) |=> (rts_n == !$past(sw_rts_req)));

endmodule

bind rxfc_rts_ctrl rxfc_rts_ctrl_chk #(
    .LEVEL_W (LEVEL_W),
    .THR_W   (THR_W),
    .HYST    (HYST),
    .MIN_THR (MIN_THR)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_level (fill_level),
    .flow_thr   (flow_thr),
    .hw_flow_en (hw_flow_en),
    .sw_rts_req (sw_rts_req),
    .rts_n      (rts_n),
    .flow_trig  (flow_trig)
);

// File: tb/test_rxfc_rts_ctrl.sv
// Bench for rxfc_rts_ctrl.
// A vector table is walked first.
// Directed tests follow for reset, the hysteresis sweep and the edges of
// the threshold.
module test_rxfc_rts_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] fill_level;
    logic [5:0] flow_thr;
    logic       hw_flow_en;
    logic       sw_rts_req;
    logic       rts_n;
    logic       flow_trig;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    rxfc_rts_ctrl i_rxfc_rts_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_level (fill_level),
        .flow_thr   (flow_thr),
        .hw_flow_en (hw_flow_en),
        .sw_rts_req (sw_rts_req),
        .rts_n      (rts_n),
        .flow_trig  (flow_trig)
    );

    // Vector fields: {hw, sw, thr[5:0], level[6:0], exp rts_n, exp trig}
    localparam int NV = 22;
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 1'b0, 6'd10, 7'd0,  1'b0, 1'b0},  // R4 idle, RTS active
        {1'b1, 1'b0, 6'd10, 7'd9,  1'b0, 1'b0},  // R1 one below: no trigger
        {1'b1, 1'b0, 6'd10, 7'd10, 1'b1, 1'b1},  // R1 R3 exactly at threshold
        {1'b1, 1'b0, 6'd10, 7'd8,  1'b1, 1'b0},  // R5 band holds off
        {1'b1, 1'b0, 6'd10, 7'd7,  1'b1, 1'b0},  // R5 band holds off
        {1'b1, 1'b0, 6'd10, 7'd6,  1'b0, 1'b0},  // R4 release at thr-4
        {1'b1, 1'b0, 6'd10, 7'd9,  1'b0, 1'b0},  // R5 band holds on
        {1'b1, 1'b0, 6'd10, 7'd12, 1'b1, 1'b1},  // R3 above threshold
        {1'b1, 1'b1, 6'd10, 7'd12, 1'b1, 1'b1},  // R8 sw bit ignored
        {1'b1, 1'b1, 6'd10, 7'd3,  1'b0, 1'b0},  // R4 R8 release
        {1'b1, 1'b0, 6'd3,  7'd20, 1'b0, 1'b0},  // R6 threshold 3 disables
        {1'b1, 1'b0, 6'd0,  7'd64, 1'b0, 1'b0},  // R6 threshold 0 disables
        {1'b0, 1'b1, 6'd10, 7'd20, 1'b0, 1'b1},  // R7 R2 sw on, trig still set
        {1'b0, 1'b0, 6'd10, 7'd20, 1'b1, 1'b1},  // R7 sw off
        {1'b0, 1'b0, 6'd10, 7'd0,  1'b1, 1'b0},  // R7 R2 level low
        {1'b1, 1'b0, 6'd4,  7'd4,  1'b1, 1'b1},  // R1 minimum valid threshold
        {1'b1, 1'b0, 6'd4,  7'd1,  1'b1, 1'b0},  // R5 band at min threshold
        {1'b1, 1'b0, 6'd4,  7'd0,  1'b0, 1'b0},  // R4 release at 0
        {1'b1, 1'b0, 6'd63, 7'd64, 1'b1, 1'b1},  // R3 full-scale threshold
        {1'b1, 1'b0, 6'd63, 7'd59, 1'b0, 1'b0},  // R4 release at 59
        {1'b1, 1'b0, 6'd10, 7'd15, 1'b1, 1'b1},  // R3 off again
        {1'b0, 1'b1, 6'd10, 7'd15, 1'b0, 1'b1}   // R7 mode switch overrides
    };

    // Compare both outputs with their expected values and count the results.
    task automatic check(input string req, input logic exp_rts_n, input logic exp_trig);
        checks++;
        if (rts_n !== exp_rts_n) begin
            errors++;
            $display("FAIL %s rts_n actual=%b expected=%b", req, rts_n, exp_rts_n);
        end
        checks++;
        if (flow_trig !== exp_trig) begin
            errors++;
            $display("FAIL %s flow_trig actual=%b expected=%b", req, flow_trig, exp_trig);
        end
    endtask

    // Drive the inputs at a falling edge; they are sampled at the next rising edge.
    task automatic drive(input logic hw, input logic sw, input logic [5:0] thr, input logic [6:0] lvl);
        hw_flow_en = hw;
        sw_rts_req = sw;
        flow_thr   = thr;
        fill_level = lvl;
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 6'd10, 7'd20);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R9", 1'b0, 1'b0);

        foreach (VEC[i]) begin
            drive(VEC[i][16], VEC[i][15], VEC[i][14:9], VEC[i][8:2]);
            @(negedge clk);
            check($sformatf("vec%0d", i), VEC[i][1], VEC[i][0]);
        end

        // R5 sweep: rise to the threshold, then drain one entry per cycle.
        drive(1'b1, 1'b0, 6'd12, 7'd12);
        @(negedge clk);
        check("R3", 1'b1, 1'b1);
        for (int lv = 11; lv >= 0; lv--) begin
            drive(1'b1, 1'b0, 6'd12, 7'(lv));
            @(negedge clk);
            check("R5", (lv > 8) ? 1'b1 : 1'b0, 1'b0);
        end

        // R9: reset in the middle of a pause state.
        drive(1'b1, 1'b0, 6'd12, 7'd30);
        @(negedge clk);
        check("R3", 1'b1, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R9", 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule